// File: doc/BRIEF.md
# Software Flow-Control Character Detector

This block sits beside a UART receiver and inspects every character that the receiver delivers. Each character is compared with four programmable match characters: two that resume transmission and two that pause it. The block gates the local transmitter through a transmit-enable output, raises a flow-control interrupt flag, and reports whether that flag was set by a pause request or by a special-character match. Characters that complete a pause or resume detection are flagged so that the receive path can drop them instead of storing them.

Two match modes exist. In single mode one character is enough: the first resume character resumes and the first pause character pauses. In paired mode the first character of a pair must be followed at once by the second; any other valid character in between restarts the match. The match characters are written through a small configuration port and are deliberately left out of reset, so a reset of the surrounding logic never clears them.

The design uses three state machines. The pair matcher has PAIR_IDLE, PAIR_ON1 (first resume character seen) and PAIR_OFF1 (first pause character seen). The transmit gate has GATE_RUN (sending allowed), GATE_DRAIN (pause requested while a character is still being shifted out) and GATE_HALT (sending blocked). Its transitions are pause-while-idle (RUN to HALT), pause-while-busy (RUN to DRAIN), drain-done (DRAIN to HALT when the transmitter goes idle) and resume (DRAIN or HALT to RUN). The interrupt controller has IRQ_IDLE, IRQ_FLOW (set by a pause detection) and IRQ_SPECIAL (set by a special-character match). Its transitions are flow-set (any state to FLOW on a pause detection), special-set (IDLE to SPECIAL), flow-clear (FLOW to IDLE on a resume detection) and read-clear (SPECIAL to IDLE on a status read).

Top module: `xfc_detect`

## Requirements
- R1: The four match characters are written with cfg_we, cfg_sel choosing the slot (0 = resume 1, 1 = resume 2, 2 = pause 1, 3 = pause 2) and cfg_data giving the value; they change only on such a write and keep their values through rst_n.
- R2: In single mode (pair_mode = 0), a valid character equal to pause 1 is a pause detection; otherwise a valid character equal to resume 1 is a resume detection. Pause wins when both slots hold the same value.
- R3: In paired mode (pair_mode = 1), a pause detection needs a valid pause 1 followed by a valid pause 2 as the next valid character, and a resume detection needs resume 1 followed by resume 2. Cycles without rx_valid do not break a pair; any other valid character restarts the match and is itself checked as a possible first character (pause 1 before resume 1). Leaving paired mode clears a half-seen pair.
- R4: On a pause detection with tx_busy low, tx_en is low from the next cycle. With tx_busy high, tx_en stays high until a cycle in which tx_busy is sampled low, and is low from the cycle after that.
- R5: On a resume detection tx_en is high from the next cycle; tx_en never rises without a resume detection.
- R6: A pause detection sets xoff_irq with irq_cause = 0 in the next cycle. That flag is cleared only by a resume detection; iir_rd has no effect on it.
- R7: With spec_en = 1, a valid character equal to pause 2 that completes no detection is a special match. From the idle state it sets xoff_irq with irq_cause = 1; that flag is cleared by iir_rd, a pause detection turns it into a flow cause, a resume detection leaves it, and a special match while a flow cause is pending leaves the flow cause. A special match in the same cycle as iir_rd keeps the flag.
- R8: rx_discard is high for exactly the one cycle after the character that completes a pause or resume detection, and low after first-of-pair characters, special matches and all other characters.
- R9: After reset tx_en = 1, xoff_irq = 0, irq_cause = 0, rx_discard = 0, and the pair matcher is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (does not touch match characters) |
| cfg_we | input | 1 | Match character write strobe |
| cfg_sel | input | 2 | Match character slot select |
| cfg_data | input | 8 | Match character write value |
| pair_mode | input | 1 | 0 = single character match, 1 = paired match |
| spec_en | input | 1 | Enables special-character matching on pause 2 |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | rx_data holds a new character this cycle |
| tx_busy | input | 1 | Transmitter is shifting a character out |
| iir_rd | input | 1 | Interrupt status read pulse |
| tx_en | output | 1 | Transmitter may start a new character |
| xoff_irq | output | 1 | Flow-control interrupt pending |
| irq_cause | output | 1 | 0 = pause detection, 1 = special match |
| rx_discard | output | 1 | Previous character completed a flow detection |

## Verification
A stuck or wrong pair-matcher state shows up one cycle after the second character of a pair, as a missing or spurious rx_discard pulse and a wrong tx_en. A wrong transmit-gate state is visible on tx_en in the cycle after the pause or resume character or after tx_busy drops, and a wrong interrupt state appears on xoff_irq and irq_cause in the cycle after the triggering character or the status read. Because every output is registered, a model stepped once per cycle can compare all four outputs every cycle and catch a divergence within one cycle of its cause; the match characters are checked to survive reset by sending a pause character straight after reset.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

    localparam int unsigned NUM_CHARS = 4;
    localparam int unsigned SEL_W     = $clog2(NUM_CHARS);

    // Slot indices of the match character bank
    localparam int unsigned SLOT_ON1  = 0;
    localparam int unsigned SLOT_ON2  = 1;
    localparam int unsigned SLOT_OFF1 = 2;
    localparam int unsigned SLOT_OFF2 = 3;

    typedef enum logic [1:0] {
        PAIR_IDLE = 2'd0,
        PAIR_ON1  = 2'd1,
        PAIR_OFF1 = 2'd2
    } pair_state_t;

    typedef enum logic [1:0] {
        GATE_RUN   = 2'd0,
        GATE_DRAIN = 2'd1,
        GATE_HALT  = 2'd2
    } gate_state_t;

    typedef enum logic [1:0] {
        IRQ_IDLE    = 2'd0,
        IRQ_FLOW    = 2'd1,
        IRQ_SPECIAL = 2'd2
    } irq_state_t;

endpackage

// File: rtl/xfc_char_bank.sv
module xfc_char_bank
    import xfc_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic                             clk,
    input  logic                             cfg_we,
    input  logic [SEL_W-1:0]                 cfg_sel,
    input  logic [CHAR_W-1:0]                cfg_data,
    output logic [NUM_CHARS-1:0][CHAR_W-1:0] chars
);

    // Match characters carry no reset: they must survive every reset.
    for (genvar i = 0; i < NUM_CHARS; i++) begin : g_slot
        logic [CHAR_W-1:0] slot_q;

        always_ff @(posedge clk) begin
            if (cfg_we && (cfg_sel == SEL_W'(i))) begin
                slot_q <= cfg_data;
            end
        end

        assign chars[i] = slot_q;
    end

endmodule

// File: rtl/xfc_matcher.sv
module xfc_matcher
    import xfc_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_CHARS-1:0][CHAR_W-1:0] chars,
    input  logic                             pair_mode,
    input  logic                             spec_en,
    input  logic [CHAR_W-1:0]                rx_data,
    input  logic                             rx_valid,
    output logic                             hit_xon,
    output logic                             hit_xoff,
    output logic                             hit_spec,
    output logic                             rx_discard
);

    pair_state_t state_q, state_d;

    logic eq_on1, eq_on2, eq_off1, eq_off2;
    logic done_on, done_off;

    assign eq_on1  = (rx_data == chars[SLOT_ON1]);
    assign eq_on2  = (rx_data == chars[SLOT_ON2]);
    assign eq_off1 = (rx_data == chars[SLOT_OFF1]);
    assign eq_off2 = (rx_data == chars[SLOT_OFF2]);

    // Completion of a detection for the current character
    always_comb begin
        done_on  = 1'b0;
        done_off = 1'b0;
        if (rx_valid) begin
            if (!pair_mode) begin
                done_off = eq_off1;
                done_on  = !eq_off1 && eq_on1;
            end else begin
                unique case (state_q)
                    PAIR_OFF1: done_off = eq_off2;
                    PAIR_ON1:  done_on  = eq_on2;
                    default: begin
                        done_on  = 1'b0;
                        done_off = 1'b0;
                    end
                endcase
            end
        end
    end

    // Next-state process for the pair matcher
    always_comb begin
        state_d = state_q;
        if (!pair_mode) begin
            state_d = PAIR_IDLE;
        end else if (rx_valid) begin
            if (done_on || done_off) begin
                state_d = PAIR_IDLE;
            end else if (eq_off1) begin
                state_d = PAIR_OFF1;
            end else if (eq_on1) begin
                state_d = PAIR_ON1;
            end else begin
                state_d = PAIR_IDLE;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PAIR_IDLE;
            rx_discard <= 1'b0;
        end else begin
            state_q    <= state_d;
            rx_discard <= done_on || done_off;
        end
    end

    // Output process
    always_comb begin
        hit_xoff = done_off;
        hit_xon  = done_on;
        hit_spec = rx_valid && spec_en && eq_off2 && !done_on && !done_off;
    end

    // R2
    hit_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_xon, hit_xoff, hit_spec}));

    // R8
    discard_follows_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_discard |-> $past(rx_valid));

    // R3
    single_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_mode |=> (state_q == PAIR_IDLE));

endmodule

// File: rtl/xfc_tx_gate.sv
module xfc_tx_gate
    import xfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_xon,
    input  logic hit_xoff,
    input  logic tx_busy,
    output logic tx_en
);

    gate_state_t state_q, state_d;

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_RUN: begin
                if (hit_xoff) begin
                    state_d = tx_busy ? GATE_DRAIN : GATE_HALT;
                end
            end
            GATE_DRAIN: begin
                if (hit_xon) begin
                    state_d = GATE_RUN;
                end else if (!tx_busy) begin
                    state_d = GATE_HALT;
                end
            end
            GATE_HALT: begin
                if (hit_xon) begin
                    state_d = GATE_RUN;
                end
            end
            default: state_d = GATE_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process
    always_comb begin
        tx_en = (state_q != GATE_HALT);
    end

    // R5
    tx_rise_needs_xon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(hit_xon));

    // R4
    tx_fall_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> !$past(tx_busy));

endmodule

// File: rtl/xfc_irq_ctl.sv
module xfc_irq_ctl
    import xfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_xon,
    input  logic hit_xoff,
    input  logic hit_spec,
    input  logic iir_rd,
    output logic xoff_irq,
    output logic irq_cause
);

    irq_state_t state_q, state_d;

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (hit_xoff) begin
                    state_d = IRQ_FLOW;
                end else if (hit_spec) begin
                    state_d = IRQ_SPECIAL;
                end
            end
            IRQ_FLOW: begin
                if (hit_xon) begin
                    state_d = IRQ_IDLE;
                end
            end
            IRQ_SPECIAL: begin
                if (hit_xoff) begin
                    state_d = IRQ_FLOW;
                end else if (hit_spec) begin
                    state_d = IRQ_SPECIAL;
                end else if (iir_rd) begin
                    state_d = IRQ_IDLE;
                end
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process
    always_comb begin
        xoff_irq  = (state_q != IRQ_IDLE);
        irq_cause = (state_q == IRQ_SPECIAL);
    end

    // R6
    flow_ignores_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xoff_irq && !irq_cause && !hit_xon) |=> (xoff_irq && !irq_cause));

    // R7
    special_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cause && iir_rd && !hit_xoff && !hit_spec) |=> !xoff_irq);

    // R6
    flow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_xoff |=> (xoff_irq && !irq_cause));

endmodule

// File: rtl/xfc_detect.sv
module xfc_detect
    import xfc_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CHAR_W-1:0] cfg_data,
    input  logic              pair_mode,
    input  logic              spec_en,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              tx_busy,
    input  logic              iir_rd,
    output logic              tx_en,
    output logic              xoff_irq,
    output logic              irq_cause,
    output logic              rx_discard
);

    logic [NUM_CHARS-1:0][CHAR_W-1:0] chars;
    logic hit_xon, hit_xoff, hit_spec;

    xfc_char_bank #(.CHAR_W(CHAR_W)) u_bank (
        .clk      (clk),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .chars    (chars)
    );

    xfc_matcher #(.CHAR_W(CHAR_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .chars      (chars),
        .pair_mode  (pair_mode),
        .spec_en    (spec_en),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .hit_xon    (hit_xon),
        .hit_xoff   (hit_xoff),
        .hit_spec   (hit_spec),
        .rx_discard (rx_discard)
    );

    xfc_tx_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_xon  (hit_xon),
        .hit_xoff (hit_xoff),
        .tx_busy  (tx_busy),
        .tx_en    (tx_en)
    );

    xfc_irq_ctl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_xon   (hit_xon),
        .hit_xoff  (hit_xoff),
        .hit_spec  (hit_spec),
        .iir_rd    (iir_rd),
        .xoff_irq  (xoff_irq),
        .irq_cause (irq_cause)
    );

    // R9
    reset_release_chk: assert property (@(posedge clk)
        !rst_n |=> (tx_en && !xoff_irq && !rx_discard));

endmodule

// File: tb/xfc_detect_bench.sv
`timescale 1ns/1ps
module xfc_detect_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_data = 8'd0;
    logic       pair_mode = 1'b0;
    logic       spec_en = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic       rx_valid = 1'b0;
    logic       tx_busy = 1'b0;
    logic       iir_rd = 1'b0;
    logic       tx_en, xoff_irq, irq_cause, rx_discard;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    xfc_detect u_xfc_detect (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .pair_mode(pair_mode), .spec_en(spec_en),
        .rx_data(rx_data), .rx_valid(rx_valid), .tx_busy(tx_busy),
        .iir_rd(iir_rd), .tx_en(tx_en), .xoff_irq(xoff_irq),
        .irq_cause(irq_cause), .rx_discard(rx_discard)
    );

    // Reference model state: gate 0 run/1 drain/2 halt, irq 0 idle/1 flow/2 special,
    // pair 0 idle/1 resume-1 seen/2 pause-1 seen
    logic [7:0] m_ch [4];
    int m_gate = 0, m_irq = 0, m_pair = 0;
    bit m_disc = 1'b0;

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "tx_en",      tx_en,      (m_gate != 2));
        check(req, "xoff_irq",   xoff_irq,   (m_irq != 0));
        check(req, "irq_cause",  irq_cause,  (m_irq == 2));
        check(req, "rx_discard", rx_discard, m_disc);
    endtask

    // Advance the model by one clock given the inputs applied this cycle
    function automatic void model_step(input logic [7:0] d, input bit v, input bit pm,
                                       input bit se, input bit busy, input bit rd);
        bit xon = 0, xoff = 0, spc = 0;
        if (v) begin
            if (!pm) begin
                xoff = (d == m_ch[2]);
                xon  = !xoff && (d == m_ch[0]);
            end else begin
                xoff = (m_pair == 2) && (d == m_ch[3]);
                xon  = (m_pair == 1) && (d == m_ch[1]);
            end
            spc = se && !xon && !xoff && (d == m_ch[3]);
        end
        // pair tracker
        if (!pm) m_pair = 0;
        else if (v) begin
            if (xon || xoff)        m_pair = 0;
            else if (d == m_ch[2])  m_pair = 2;
            else if (d == m_ch[0])  m_pair = 1;
            else                    m_pair = 0;
        end
        // gate
        case (m_gate)
            0: if (xoff) m_gate = busy ? 1 : 2;
            1: if (xon) m_gate = 0; else if (!busy) m_gate = 2;
            default: if (xon) m_gate = 0;
        endcase
        // interrupt
        case (m_irq)
            0: if (xoff) m_irq = 1; else if (spc) m_irq = 2;
            1: if (xon) m_irq = 0;
            default: if (xoff) m_irq = 1; else if (spc) m_irq = 2; else if (rd) m_irq = 0;
        endcase
        m_disc = xon || xoff;
    endfunction

    // Called at a falling edge; returns at the next falling edge after comparing
    task automatic step(input string req, input logic [7:0] d, input bit v, input bit pm,
                        input bit se, input bit busy, input bit rd);
        rx_data = d; rx_valid = v; pair_mode = pm; spec_en = se; tx_busy = busy; iir_rd = rd;
        @(posedge clk);
        model_step(d, v, pm, se, busy, rd);
        @(negedge clk);
        check_all(req);
    endtask

    task automatic idle(input string req, input bit pm);
        step(req, 8'h00, 1'b0, pm, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic write_char(input int slot, input logic [7:0] val);
        cfg_we = 1'b1; cfg_sel = 2'(slot); cfg_data = val;
        @(posedge clk);
        m_ch[slot] = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rx_valid = 1'b0; iir_rd = 1'b0; tx_busy = 1'b0;
        repeat (2) @(posedge clk);
        m_gate = 0; m_irq = 0; m_pair = 0; m_disc = 0;
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R9");
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1977));
        @(negedge clk);
        // R1: program slots (0 resume1, 1 resume2, 2 pause1, 3 pause2)
        write_char(0, 8'h11);
        write_char(1, 8'h12);
        write_char(2, 8'h13);
        write_char(3, 8'h14);
        do_reset();

        // R2 / R4 / R6 / R8: single-mode pause, transmitter idle
        step("R2", 8'h13, 1, 0, 0, 0, 0);
        step("R6", 8'h55, 0, 0, 0, 0, 1);   // read does not clear flow cause
        step("R5", 8'h11, 1, 0, 0, 0, 0);   // resume
        // R4: pause while busy -> drain, then halt
        step("R4", 8'h13, 1, 0, 0, 1, 0);
        step("R4", 8'h00, 0, 0, 0, 1, 0);
        step("R4", 8'h00, 0, 0, 0, 0, 0);
        step("R5", 8'h11, 1, 0, 0, 0, 0);
        // R7: special match, cleared by read, read+special keeps it
        step("R7", 8'h14, 1, 0, 1, 0, 0);
        step("R7", 8'h11, 1, 0, 1, 0, 0);   // resume leaves special
        step("R7", 8'h14, 1, 0, 1, 0, 1);   // special with read keeps flag
        step("R7", 8'h00, 0, 0, 1, 0, 1);   // read clears
        step("R7", 8'h14, 1, 0, 1, 0, 0);
        step("R7", 8'h13, 1, 0, 1, 0, 0);   // pause overrides to flow
        step("R7", 8'h14, 1, 0, 1, 0, 1);   // special keeps flow cause
        step("R5", 8'h11, 1, 0, 1, 0, 0);
        // R3: paired mode with gaps and restarts
        step("R3", 8'h13, 1, 1, 0, 0, 0);
        idle("R3", 1);
        step("R3", 8'h14, 1, 1, 0, 0, 0);   // completes pause
        step("R3", 8'h11, 1, 1, 0, 0, 0);
        step("R3", 8'h77, 1, 1, 0, 0, 0);   // breaks pair
        step("R3", 8'h12, 1, 1, 0, 0, 0);   // no resume
        step("R3", 8'h11, 1, 1, 0, 0, 0);
        step("R3", 8'h13, 1, 1, 0, 0, 0);   // restart as pause-1
        step("R3", 8'h11, 1, 1, 0, 0, 0);
        step("R8", 8'h12, 1, 1, 0, 0, 0);   // resume completes
        step("R3", 8'h13, 1, 1, 0, 0, 0);
        step("R3", 8'h14, 1, 0, 0, 0, 0);   // mode drop clears half pair
        // R2: same value in both single-mode slots -> pause wins
        write_char(0, 8'h13);
        step("R2", 8'h13, 1, 0, 0, 0, 0);
        write_char(0, 8'h11);
        step("R5", 8'h11, 1, 0, 0, 0, 0);
        // R1: pause after reset still detected
        do_reset();
        step("R1", 8'h13, 1, 0, 0, 0, 0);
        step("R1", 8'h11, 1, 0, 0, 0, 0);

        // Random phase
        begin
            bit pm = 0, se = 1;
            for (int i = 0; i < 4000; i++) begin
                logic [7:0] d;
                int r = $urandom_range(0, 9);
                if (r < 7) d = m_ch[$urandom_range(0, 3)];
                else d = 8'($urandom);
                if ($urandom_range(0, 99) == 0) pm = !pm;
                if ($urandom_range(0, 49) == 0) se = !se;
                step(pm ? "R3" : "R2", d, ($urandom_range(0, 9) < 8), pm, se,
                     1'($urandom), ($urandom_range(0, 9) == 0));
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule